// File: doc/BRIEF.md
# PWM Input Capture Channel

One timer input channel that turns an external digital waveform into pulse measurements. The raw pin goes through a synchronizer and a programmable glitch filter. The cleaned level is then timed against a measurement counter that moves only on an external clock enable (`tick`). Every channel-clock cycle with `tick` high is one time unit. The period, the high time and the low time of the waveform are all measured from the same counters.

Each measurement starts and ends on a rising edge of the filtered level. When a rising edge closes a full period, the channel builds one result word and holds it on a valid/ready port for a downstream router. The word has two fields of the counter width. The second field is always the period. The first field is either the high time or the low time, chosen by a configuration bit. If the consumer has not taken a word when the next one is ready, the new word replaces the old one and is tagged with an overflow bit.

A separate counter watches for missing activity. When no filtered edge of either polarity has been seen for a programmed number of ticks, the channel raises a timeout flag. The next edge clears it.

Top module: `pwm_capture_chan`

## Requirements
- R1: The raw input passes through a two-flop synchronizer. The filtered level takes a new value only on the `cfg_filt_len`-th consecutive ticked sample that differs from it. Any ticked sample equal to the filtered level restarts the run. A length of 0 behaves as 1.
- R2: The filtered level never changes on a cycle that follows a cycle with `tick` low.
- R3: The period counter and the high-time counter advance only on cycles with `tick` high. The high-time counter also requires the filtered level to be 1. A filtered rising edge captures both counters and restarts them from 0. The tick in that same cycle is not counted.
- R4: The first filtered rising edge after reset only arms the channel and produces no result.
- R5: For each later rising edge, a result is loaded one cycle after the edge pulse. `res_data1` holds the period. `res_data0` holds the high time when `cfg_low_sel`=0, or period minus high time when `cfg_low_sel`=1. So `res_data0` never exceeds `res_data1`.
- R6: All counters saturate at their all-ones value (24'hFFFFFF by default) instead of wrapping.
- R7: `res_valid` stays high and the data fields stay unchanged until a cycle with `res_ready` high. A transfer then clears `res_valid`, unless a new result loads in the same cycle.
- R8: A result that loads while an untaken result is still present sets `res_ovf` to 1. A result that loads into an empty or accepted slot sets `res_ovf` to 0.
- R9: `timeout` rises one cycle after the edge-free tick count reaches `cfg_tmo_limit`, and clears one cycle after any filtered edge. A limit of 0 never sets it.
- R10: In reset, `res_valid`, `res_ovf`, `timeout` and both data fields are 0, and the filtered level is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel clock |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Raw asynchronous input signal |
| tick | input | 1 | Clock enable for the filter and the counters |
| cfg_filt_len | input | FW (8) | Number of consecutive ticked samples needed to accept a new level |
| cfg_tmo_limit | input | CW (24) | Edge-free tick count that raises the timeout; 0 disables it |
| cfg_low_sel | input | 1 | 0: field 0 is the high time; 1: field 0 is the low time |
| res_valid | output | 1 | A result word is presented |
| res_ready | input | 1 | Consumer takes the presented word |
| res_data0 | output | CW (24) | High or low time in ticks |
| res_data1 | output | CW (24) | Period in ticks |
| res_ovf | output | 1 | Presented word replaced an unconsumed one |
| timeout | output | 1 | No filtered edge within the limit |

## Verification
The stimulus includes glitches shorter than the filter length. A filter that counted total differing samples instead of consecutive ones would accept those glitches and report short, wrong periods. Sparse ticks and long edge-free stretches probe the counter enables and the saturation. A narrow-width second instance pins the saturated period; a wrapping counter there would report a small period. Held-off and alternating ready patterns force overwrites: a design that dropped the new word, or kept the overflow bit sticky, would disagree with the reference on the data or on `res_ovf`. Timeout runs with a zero limit and with a limit reached inside a long high phase check the flag's set and clear points.

// File: rtl/pcap_pkg.sv
package pcap_pkg;

  localparam int unsigned PCAP_CW_DEF = 24;
  localparam int unsigned PCAP_FW_DEF = 8;

  typedef enum logic {
    FIELD_HIGH = 1'b0,
    FIELD_LOW  = 1'b1
  } field_sel_e;

endpackage

// File: rtl/pcap_satcnt.sv
module pcap_satcnt #(
  parameter int unsigned W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (inc && (q != TOP)) begin
      q <= q + 1'b1;
    end
  end

endmodule

// File: rtl/pcap_sync_filter.sv
module pcap_sync_filter #(
  parameter int unsigned SYNC = 2,
  parameter int unsigned FW   = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          sig_in,
  input  logic [FW-1:0] filt_len,
  output logic          lvl,
  output logic          rise,
  output logic          fall
);

  logic [SYNC-1:0] sy;
  logic [FW-1:0]   run;
  logic            smp;
  logic [FW:0]     need;
  logic [FW:0]     run_nx;

  generate
    if (SYNC == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sy <= '0;
        else     sy <= sig_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sy <= '0;
        else     sy <= {sy[SYNC-2:0], sig_in};
      end
    end
  endgenerate

  assign smp    = sy[SYNC-1];
  assign need   = (filt_len == '0) ? {{FW{1'b0}}, 1'b1} : {1'b0, filt_len};
  assign run_nx = {1'b0, run} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl  <= 1'b0;
      run  <= '0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      rise <= 1'b0;
      fall <= 1'b0;
      if (tick) begin
        if (smp != lvl) begin
          if (run_nx >= need) begin
            lvl  <= smp;
            run  <= '0;
            rise <= smp;
            fall <= ~smp;
          end else begin
            run <= run_nx[FW-1:0];
          end
        end else begin
          run <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/pcap_measure.sv
module pcap_measure #(
  parameter int unsigned CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          lvl,
  input  logic          rise,
  input  logic          fall,
  input  logic [CW-1:0] tmo_limit,
  output logic          cap_stb,
  output logic [CW-1:0] cap_period,
  output logic [CW-1:0] cap_high,
  output logic          timeout
);

  logic          armed;
  logic          any_edge;
  logic [CW-1:0] per_q;
  logic [CW-1:0] hi_q;
  logic [CW-1:0] idle_q;

  assign any_edge = rise | fall;

  pcap_satcnt #(.W(CW)) u_per (
    .clk(clk), .rst(rst), .clr(rise), .inc(tick), .q(per_q)
  );

  pcap_satcnt #(.W(CW)) u_hi (
    .clk(clk), .rst(rst), .clr(rise), .inc(tick & lvl), .q(hi_q)
  );

  pcap_satcnt #(.W(CW)) u_idle (
    .clk(clk), .rst(rst), .clr(any_edge), .inc(tick), .q(idle_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (rise) begin
      armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || any_edge) begin
      timeout <= 1'b0;
    end else if ((tmo_limit != '0) && (idle_q >= tmo_limit)) begin
      timeout <= 1'b1;
    end
  end

  assign cap_stb    = rise & armed;
  assign cap_period = per_q;
  assign cap_high   = hi_q;

endmodule

// File: rtl/pcap_result.sv
module pcap_result #(
  parameter int unsigned CW = 24
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cap_stb,
  input  logic [CW-1:0]        cap_period,
  input  logic [CW-1:0]        cap_high,
  input  pcap_pkg::field_sel_e sel,
  input  logic                 ready,
  output logic                 valid,
  output logic [CW-1:0]        data0,
  output logic [CW-1:0]        data1,
  output logic                 ovf
);

  logic [CW-1:0] field0;

  always_comb begin
    if (sel == pcap_pkg::FIELD_LOW) field0 = cap_period - cap_high;
    else                            field0 = cap_high;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data0 <= '0;
      data1 <= '0;
      ovf   <= 1'b0;
    end else if (cap_stb) begin
      valid <= 1'b1;
      data0 <= field0;
      data1 <= cap_period;
      ovf   <= valid & ~ready;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_capture_chan.sv
module pwm_capture_chan #(
  parameter int unsigned CW   = pcap_pkg::PCAP_CW_DEF,
  parameter int unsigned FW   = pcap_pkg::PCAP_FW_DEF,
  parameter int unsigned SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sig_in,
  input  logic          tick,
  input  logic [FW-1:0] cfg_filt_len,
  input  logic [CW-1:0] cfg_tmo_limit,
  input  logic          cfg_low_sel,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [CW-1:0] res_data0,
  output logic [CW-1:0] res_data1,
  output logic          res_ovf,
  output logic          timeout
);

  logic          filt_lvl;
  logic          filt_rise;
  logic          filt_fall;
  logic          cap_stb;
  logic [CW-1:0] cap_period;
  logic [CW-1:0] cap_high;
  pcap_pkg::field_sel_e sel;

  assign sel = pcap_pkg::field_sel_e'(cfg_low_sel);

  pcap_sync_filter #(.SYNC(SYNC), .FW(FW)) u_filt (
    .clk(clk), .rst(rst), .tick(tick), .sig_in(sig_in),
    .filt_len(cfg_filt_len), .lvl(filt_lvl), .rise(filt_rise), .fall(filt_fall)
  );

  pcap_measure #(.CW(CW)) u_meas (
    .clk(clk), .rst(rst), .tick(tick), .lvl(filt_lvl),
    .rise(filt_rise), .fall(filt_fall), .tmo_limit(cfg_tmo_limit),
    .cap_stb(cap_stb), .cap_period(cap_period), .cap_high(cap_high),
    .timeout(timeout)
  );

  pcap_result #(.CW(CW)) u_res (
    .clk(clk), .rst(rst), .cap_stb(cap_stb), .cap_period(cap_period),
    .cap_high(cap_high), .sel(sel), .ready(res_ready),
    .valid(res_valid), .data0(res_data0), .data1(res_data1), .ovf(res_ovf)
  );

endmodule

// File: rtl/pcap_checker.sv
module pcap_checker #(
  parameter int unsigned CW = 24
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          lvl,
  input logic [CW-1:0] cfg_tmo_limit,
  input logic          res_valid,
  input logic          res_ready,
  input logic [CW-1:0] res_data0,
  input logic [CW-1:0] res_data1,
  input logic          res_ovf,
  input logic          timeout
);

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> res_valid);  // R7

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_ready |=> (($stable(res_data0) && $stable(res_data1)) || res_ovf));  // R7

  AST_FIELD_BOUND: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_data0 <= res_data1));  // R5

  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(res_ovf) |-> $past(res_valid && !res_ready));  // R8

  AST_LVL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(lvl));  // R2

  AST_TMO_EDGE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (lvl != $past(lvl)) |=> !timeout);  // R9

  AST_TMO_OFF: assert property (@(posedge clk) disable iff (rst)
    (cfg_tmo_limit == '0) && !timeout |=> !timeout);  // R9

endmodule

bind pwm_capture_chan pcap_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .lvl(filt_lvl),
  .cfg_tmo_limit(cfg_tmo_limit), .res_valid(res_valid), .res_ready(res_ready),
  .res_data0(res_data0), .res_data1(res_data1), .res_ovf(res_ovf),
  .timeout(timeout)
);

// File: tb/pcap_model.sv
module pcap_model #(
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sig,
  input  logic          tick,
  input  logic [7:0]    filt_len,
  input  logic [CW-1:0] tmo_lim,
  input  logic          low_sel,
  input  logic          ready,
  output logic          e_valid,
  output logic [CW-1:0] e_d0,
  output logic [CW-1:0] e_d1,
  output logic          e_ovf,
  output logic          e_tmo
);

  longint top;
  int     pipe[$];
  int     level, run, rise_p, fall_p, armed;
  longint per, hi, idle;

  initial top = (longint'(1) << CW) - 1;

  always @(posedge clk) begin : step
    int     s, need, n_rise, n_fall;
    longint cp, ch;
    bit     cap, edge_seen;
    if (rst) begin
      pipe = {0, 0};
      level = 0; run = 0; rise_p = 0; fall_p = 0; armed = 0;
      per = 0; hi = 0; idle = 0;
      e_valid <= 0; e_d0 <= '0; e_d1 <= '0; e_ovf <= 0; e_tmo <= 0;
    end else begin
      s = pipe.pop_front();
      pipe.push_back(int'(sig));
      cap = (rise_p != 0) && (armed != 0);
      cp = per; ch = hi;
      edge_seen = (rise_p != 0) || (fall_p != 0);
      if (edge_seen) e_tmo <= 0;
      else if (tmo_lim != 0 && idle >= longint'(tmo_lim)) e_tmo <= 1;
      if (cap) begin
        e_ovf   <= e_valid && !ready;
        e_valid <= 1;
        e_d1    <= cp[CW-1:0];
        e_d0    <= low_sel ? CW'(cp - ch) : ch[CW-1:0];
      end else if (e_valid && ready) begin
        e_valid <= 0;
      end
      if (rise_p != 0) begin per = 0; hi = 0; armed = 1; end
      else if (tick) begin
        if (per < top) per++;
        if (level != 0 && hi < top) hi++;
      end
      if (edge_seen) idle = 0;
      else if (tick && idle < top) idle++;
      n_rise = 0; n_fall = 0;
      need = (filt_len == 0) ? 1 : int'(filt_len);
      if (tick) begin
        if (s != level) begin
          if (run + 1 >= need) begin
            level = s; run = 0; n_rise = s; n_fall = 1 - s;
          end else run++;
        end else run = 0;
      end
      rise_p = n_rise; fall_p = n_fall;
    end
  end

endmodule

// File: tb/pwm_capture_chan_tb.sv
`timescale 1ns/1ps
module pwm_capture_chan_tb;

  logic        clk = 0;
  logic        rst = 1;
  logic        sig = 0;
  logic        tick = 1;
  logic [7:0]  filt = 8'd3;
  logic [23:0] tmo = 24'd50;
  logic        lsel = 0;
  logic        rdy = 1;
  int          tick_div = 1;
  int          rdy_mode = 0;
  int          n_chk = 0;
  int          n_err = 0;
  bit          running = 0;

  logic        v, ov, to, ev, eov, eto;
  logic [23:0] d0, d1, ed0, ed1;
  logic        sv, sov, sto, esv, esov, esto;
  logic [7:0]  sd0, sd1, esd0, esd1;

  always #4 clk = ~clk;

  pwm_capture_chan u_dut (
    .clk(clk), .rst(rst), .sig_in(sig), .tick(tick), .cfg_filt_len(filt),
    .cfg_tmo_limit(tmo), .cfg_low_sel(lsel), .res_valid(v), .res_ready(rdy),
    .res_data0(d0), .res_data1(d1), .res_ovf(ov), .timeout(to)
  );

  pwm_capture_chan #(.CW(8)) u_sat (
    .clk(clk), .rst(rst), .sig_in(sig), .tick(tick), .cfg_filt_len(filt),
    .cfg_tmo_limit(tmo[7:0]), .cfg_low_sel(lsel), .res_valid(sv), .res_ready(rdy),
    .res_data0(sd0), .res_data1(sd1), .res_ovf(sov), .timeout(sto)
  );

  pcap_model #(.CW(24)) u_ref (
    .clk(clk), .rst(rst), .sig(sig), .tick(tick), .filt_len(filt), .tmo_lim(tmo),
    .low_sel(lsel), .ready(rdy), .e_valid(ev), .e_d0(ed0), .e_d1(ed1),
    .e_ovf(eov), .e_tmo(eto)
  );

  pcap_model #(.CW(8)) u_ref_s (
    .clk(clk), .rst(rst), .sig(sig), .tick(tick), .filt_len(filt), .tmo_lim(tmo[7:0]),
    .low_sel(lsel), .ready(rdy), .e_valid(esv), .e_d0(esd0), .e_d1(esd1),
    .e_ovf(esov), .e_tmo(esto)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // tick and ready drivers
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      tick = (tick_div <= 1) ? 1'b1 : ((c % tick_div) == 0);
      case (rdy_mode)
        0: rdy = 1'b1;
        1: rdy = 1'b0;
        default: rdy = ((c / 3) % 2) == 0;
      endcase
    end
  end

  // cycle-by-cycle comparison against the reference model
  initial begin
    forever begin
      @(negedge clk);
      if (running) begin
        chk(v == ev, "R4 R7 valid", v, ev);
        chk(d0 == ed0, "R1 R3 R5 data0", d0, ed0);
        chk(d1 == ed1, "R1 R3 R5 data1 period", d1, ed1);
        chk(ov == eov, "R8 overflow", ov, eov);
        chk(to == eto, "R9 timeout", to, eto);
        chk(sv == esv, "R6 narrow valid", sv, esv);
        chk(sd0 == esd0, "R6 narrow data0", sd0, esd0);
        chk(sd1 == esd1, "R6 narrow data1", sd1, esd1);
        chk(sto == esto, "R6 R9 narrow timeout", sto, esto);
      end
    end
  end

  task automatic pwm(input int h, input int l, input int n);
    for (int i = 0; i < n; i++) begin
      sig = 1'b1;
      repeat (h) @(negedge clk);
      sig = 1'b0;
      repeat (l) @(negedge clk);
    end
  endtask

  task automatic glitchy(input int h, input int l, input int n);
    for (int i = 0; i < n; i++) begin
      sig = 1'b1; repeat (h / 2) @(negedge clk);
      sig = 1'b0; repeat (2) @(negedge clk);
      sig = 1'b1; repeat (h / 2) @(negedge clk);
      sig = 1'b0; repeat (l / 2) @(negedge clk);
      sig = 1'b1; @(negedge clk);
      sig = 1'b0; repeat (l / 2) @(negedge clk);
    end
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10 reset state
    chk(v == 0 && ov == 0 && to == 0, "R10 reset flags", {v, ov, to}, 0);
    chk(d0 == 0 && d1 == 0, "R10 reset data", d0 | d1, 0);
    rst = 0;
    running = 1;
    // R4 first edge only arms
    sig = 1'b1;
    repeat (12) @(negedge clk);
    chk(v == 0, "R4 no result after first edge", v, 0);
    sig = 1'b0;
    repeat (30) @(negedge clk);
    pwm(20, 30, 5);
    // R5 low-time field, sparse ticks, alternating ready
    lsel = 1; tick_div = 3; rdy_mode = 2;
    pwm(25, 40, 4);
    pwm(60, 15, 3);
    // R1 glitches shorter than filter
    tick_div = 1; filt = 8'd4; rdy_mode = 0;
    glitchy(30, 30, 4);
    // R8 held-off consumer
    rdy_mode = 1; lsel = 0;
    pwm(15, 15, 4);
    rdy_mode = 0;
    repeat (5) @(negedge clk);
    rdy_mode = 1;
    pwm(12, 9, 2);
    rdy_mode = 0;
    // R1 zero filter length
    filt = 8'd0;
    pwm(7, 5, 4);
    // R6 R9 long high and long low with timeout
    filt = 8'd2; tmo = 24'd100;
    pwm(600, 300, 2);
    // R9 limit zero disables
    tmo = 24'd0;
    pwm(400, 10, 1);
    tmo = 24'd30; tick_div = 2;
    pwm(50, 50, 3);
    repeat (20) @(negedge clk);
    running = 0;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule